// File: doc/BRIEF.md
# Graphics DRAM Extended Mode Register Controller

This block models the extended mode register logic of a graphics DRAM as seen from its command/address pins. It decodes the extended mode register set command (EMRS), keeps the write-recovery, termination and output-driver fields, and tracks whether the delay-locked loop is on and whether its lock interval has run out. READ commands that arrive before the lock interval has run out are flagged as illegal. The rest of the device uses the `read_ok` level to decide whether a read may start.

An EMRS with address bit 10 set puts the block into identification readout. After a programmable on-delay, a fixed byte is driven onto the lower data byte. The low nibble is vendor code 4'b0010 and the high nibble is revision 4'b0011, so the bus carries 8'h32. A later EMRS with bit 10 clear ends the mode. After a programmable off-delay the bus is driven to all ones. While the mode is active, every other command is refused. The write-recovery map, mid-range or high-speed, is fixed by a parameter.

Commands are qualified by `cmd_valid` and coded on `cmd_code`: 0 activate, 1 read, 2 write, 3 precharge, 4 refresh, 5 self-refresh entry, 6 self-refresh exit, 7 EMRS. The EMRS fields sit on `cmd_addr`:
- A1:A0 selects termination.
- A3:A2 selects driver strength.
- A6 disables the DLL when set.
- {A7,A5,A4} is the write-recovery code.
- A10 enters or exits identification mode.

Top module: `gdram_xmode_ctrl`

## Requirements
- R1: While and after reset, `read_ok`, `dll_on`, `cmd_illegal` and `dq_oe` are 0, `dq_out` is 0, `term_sel` and `drv_sel` are 0, and `wr_cycles` equals the minimum of the active map.
- R2: An accepted EMRS with A10=0 and A6=0, issued while the DLL is off, turns the DLL on and raises `read_ok` exactly LOCK_CYCLES clock edges after the command edge. An accepted EMRS with A10=0 and A6=1 turns the DLL off and drops `read_ok` after the command edge.
- R3: `cmd_illegal` is high for the single cycle that follows the edge of a refused command. A READ sampled while `read_ok` is low is refused, and a READ sampled while it is high is accepted.
- R4: Self-refresh entry (code 5) drops `read_ok`. Inside self-refresh, every command other than exit (code 6) is refused. Exit turns the DLL on and restarts the full LOCK_CYCLES count. An exit outside self-refresh is refused.
- R5: The write-recovery code c = {A7,A5,A4} gives `wr_cycles` = c+4 in the mid-range map (all codes valid). It gives c+7 in the high-speed map, where code 7 is refused.
- R6: A1:A0 selects termination on `term_sel` (00 disabled, 01 ZQ/4, 10 ZQ/2), and code 11 is refused. A3:A2 is latched unchanged onto `drv_sel`.
- R7: A refused EMRS changes no field and no DLL state.
- R8: An EMRS with A10=1 releases the bus (`dq_oe`=0). Exactly ID_ON_DLY edges later, `dq_out` becomes 8'h32 with `dq_oe`=1, unless an exit arrives first.
- R9: An EMRS with A10=0 during identification mode leaves `dq_out`/`dq_oe` unchanged for ID_OFF_DLY edges and changes no field. After that it drives 8'hFF with `dq_oe`=1 until the next valid command, whose edge releases the bus.
- R10: From the entering EMRS until the exiting one, every other command, including another EMRS with A10=1, is refused and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 3 | Command code |
| cmd_addr | input | 12 | Address bits A11..A0 carried with the command |
| read_ok | output | 1 | DLL on, locked, and not in self-refresh |
| cmd_illegal | output | 1 | Previous command was refused |
| dll_on | output | 1 | DLL enabled |
| dq_out | output | 8 | Value driven on the lower data byte |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| wr_cycles | output | 4 | Write recovery in clock cycles |
| term_sel | output | 2 | Termination selection |
| drv_sel | output | 2 | Driver strength selection |

## Verification
The bench builds the block with LOCK_CYCLES=20, ID_ON_DLY=4 and ID_OFF_DLY=3, so lock boundaries can be probed with back-to-back READs inside a short run. A second copy uses the mid-range map, so write-recovery code 7 is refused by one copy and accepted by the other under identical stimulus. The short delays also let exit commands be placed at every offset of the on-delay window, including the edge where the identification byte would appear.

// File: rtl/gdram_xmode_pkg.sv
// Shared command codes, state encodings and the decoded-action record for
// the extended mode register controller. Assumes 3-bit command codes.
package gdram_xmode_pkg;

    typedef enum logic [2:0] {
        CMD_ACT      = 3'd0,
        CMD_READ     = 3'd1,
        CMD_WRITE    = 3'd2,
        CMD_PRE      = 3'd3,
        CMD_REF      = 3'd4,
        CMD_SR_ENTER = 3'd5,
        CMD_SR_EXIT  = 3'd6,
        CMD_EMRS     = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ID_IDLE     = 3'd0,
        ID_ON_WAIT  = 3'd1,
        ID_SHOW     = 3'd2,
        ID_OFF_WAIT = 3'd3,
        ID_HIGH     = 3'd4
    } id_state_e;

    // One flag per effect a command can have; at most one group fires.
    typedef struct packed {
        logic dll_enable;
        logic dll_disable;
        logic sr_enter;
        logic sr_exit;
        logic id_enter;
        logic id_exit;
        logic fields_wr;
        logic illegal;
    } cmd_act_t;

    localparam logic [3:0] VENDOR_NIBBLE   = 4'b0010;
    localparam logic [3:0] REVISION_NIBBLE = 4'b0011;
    localparam logic [7:0] ID_BYTE         = {REVISION_NIBBLE, VENDOR_NIBBLE};
    localparam logic [1:0] TERM_RESERVED   = 2'b11;

endpackage

// File: rtl/gdram_xmode_decode.sv
// Combinational command classifier. Turns one command plus the current
// mode state into an action record. Assumes that identification mode
// outranks self-refresh, which outranks normal decoding.
module gdram_xmode_decode
    import gdram_xmode_pkg::*;
#(
    parameter bit HIGH_SPEED_MAP = 1'b1
) (
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_code,
    input  logic [11:0] cmd_addr,
    input  logic        id_active,
    input  logic        in_sref,
    input  logic        dll_on,
    input  logic        read_ok,
    output cmd_act_t    act,
    output logic [2:0]  wr_code,
    output logic [1:0]  term_code,
    output logic [1:0]  drv_code
);

    cmd_e cmd;
    logic field_bad;
    logic unused_addr;

    assign cmd         = cmd_e'(cmd_code);
    assign wr_code     = {cmd_addr[7], cmd_addr[5], cmd_addr[4]};
    assign term_code   = cmd_addr[1:0];
    assign drv_code    = cmd_addr[3:2];
    assign unused_addr = ^{cmd_addr[11], cmd_addr[9:8]};

    // Field validity: reserved termination, or write-recovery code beyond the map.
    generate
        if (HIGH_SPEED_MAP) begin : g_hs_map
            assign field_bad = (term_code == TERM_RESERVED) || (wr_code == 3'd7);
        end else begin : g_mid_map
            assign field_bad = (term_code == TERM_RESERVED);
        end
    endgenerate

    // Classify the command into exactly one action group.
    always_comb begin
        act = '0;
        if (cmd_valid) begin
            if (id_active) begin
                if (cmd == CMD_EMRS && !cmd_addr[10]) act.id_exit = 1'b1;
                else                                  act.illegal = 1'b1;
            end else if (in_sref) begin
                if (cmd == CMD_SR_EXIT) act.sr_exit = 1'b1;
                else                    act.illegal = 1'b1;
            end else begin
                case (cmd)
                    CMD_READ:     act.illegal  = !read_ok;
                    CMD_SR_ENTER: act.sr_enter = 1'b1;
                    CMD_SR_EXIT:  act.illegal  = 1'b1;
                    CMD_EMRS: begin
                        if (cmd_addr[10]) begin
                            act.id_enter = 1'b1;
                        end else if (field_bad) begin
                            act.illegal = 1'b1;
                        end else begin
                            act.fields_wr = 1'b1;
                            if (cmd_addr[6])  act.dll_disable = 1'b1;
                            else if (!dll_on) act.dll_enable  = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/gdram_xmode_dll.sv
// DLL enable, lock-interval counter and self-refresh tracking. Assumes the
// lock interval counts clock edges from the enabling command's edge.
module gdram_xmode_dll
    import gdram_xmode_pkg::*;
#(
    parameter int LOCK_CYCLES = 1000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_act_t act,
    output logic     dll_on,
    output logic     in_sref,
    output logic     read_ok
);

    localparam int LCW = $clog2(LOCK_CYCLES + 1);

    logic [LCW-1:0] lock_cnt;

    // DLL state and lock countdown; an enable or refresh exit reloads it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_on   <= 1'b0;
            lock_cnt <= '0;
        end else if (act.dll_enable || act.sr_exit) begin
            dll_on   <= 1'b1;
            lock_cnt <= LCW'(LOCK_CYCLES);
        end else if (act.dll_disable) begin
            dll_on   <= 1'b0;
            lock_cnt <= '0;
        end else if (lock_cnt != '0) begin
            lock_cnt <= lock_cnt - 1'b1;
        end
    end

    // Self-refresh residency flag.
    always_ff @(posedge clk) begin
        if (!rst_n)           in_sref <= 1'b0;
        else if (act.sr_enter) in_sref <= 1'b1;
        else if (act.sr_exit)  in_sref <= 1'b0;
    end

    assign read_ok = dll_on && (lock_cnt == '0) && !in_sref;

    p_enable_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act.dll_enable |=> (dll_on && !read_ok));
    p_disable_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act.dll_disable |=> (!dll_on && !read_ok));
    p_sref_exit_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act.sr_exit |=> (dll_on && !read_ok && !in_sref));
    p_sref_enter_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act.sr_enter |=> !read_ok);

endmodule

// File: rtl/gdram_xmode_fields.sv
// Holds the write-recovery, termination and driver fields. These are
// written only by an accepted EMRS. Assumes the decoder has already
// rejected invalid codes.
module gdram_xmode_fields
    import gdram_xmode_pkg::*;
#(
    parameter bit HIGH_SPEED_MAP = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_act_t   act,
    input  logic [2:0] wr_code_in,
    input  logic [1:0] term_in,
    input  logic [1:0] drv_in,
    output logic [3:0] wr_cycles,
    output logic [1:0] term_sel,
    output logic [1:0] drv_sel
);

    localparam int WR_BASE = HIGH_SPEED_MAP ? 7 : 4;
    localparam int WR_MAX  = HIGH_SPEED_MAP ? 13 : 11;

    logic [2:0] wr_code_q;

    // Field capture on an accepted EMRS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_code_q <= '0;
            term_sel  <= '0;
            drv_sel   <= '0;
        end else if (act.fields_wr) begin
            wr_code_q <= wr_code_in;
            term_sel  <= term_in;
            drv_sel   <= drv_in;
        end
    end

    assign wr_cycles = 4'(WR_BASE) + {1'b0, wr_code_q};

    p_wr_in_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cycles >= 4'(WR_BASE)) && (wr_cycles <= 4'(WR_MAX)));
    p_term_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        term_sel != TERM_RESERVED);
    p_reject_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act.illegal |=> ($stable(wr_cycles) && $stable(term_sel) && $stable(drv_sel)));
    p_exit_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act.id_exit |=> ($stable(wr_cycles) && $stable(term_sel) && $stable(drv_sel)));

endmodule

// File: rtl/gdram_xmode_idread.sv
// Identification readout sequencer. It applies the on-delay, shows the ID
// byte, applies the off-delay, and then parks the bus high until the next
// command. Assumes both delays are at least one cycle.
module gdram_xmode_idread
    import gdram_xmode_pkg::*;
#(
    parameter int ON_DLY  = 4,
    parameter int OFF_DLY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_act_t   act,
    input  logic       cmd_valid,
    output logic       id_active,
    output logic [7:0] dq_out,
    output logic       dq_oe
);

    localparam int MAX_DLY = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
    localparam int CW      = $clog2(MAX_DLY + 1);

    id_state_e       state;
    logic [CW-1:0]   dly_cnt;
    logic            cnt_done;

    assign cnt_done  = (dly_cnt == '0);
    assign id_active = (state == ID_ON_WAIT) || (state == ID_SHOW);

    // Sequencer state and delay counter; exit outranks entry and timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ID_IDLE;
            dly_cnt <= '0;
        end else if (act.id_exit) begin
            state   <= ID_OFF_WAIT;
            dly_cnt <= CW'(OFF_DLY - 1);
        end else if (act.id_enter) begin
            state   <= ID_ON_WAIT;
            dly_cnt <= CW'(ON_DLY - 1);
        end else begin
            case (state)
                ID_ON_WAIT: begin
                    if (cnt_done) state <= ID_SHOW;
                    else          dly_cnt <= dly_cnt - 1'b1;
                end
                ID_OFF_WAIT: begin
                    if (cnt_done) state <= ID_HIGH;
                    else          dly_cnt <= dly_cnt - 1'b1;
                end
                ID_HIGH: if (cmd_valid) state <= ID_IDLE;
                default: ;
            endcase
        end
    end

    // Data byte and drive enable; they change only at phase boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else if (act.id_enter) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else if (!act.id_exit) begin
            if (state == ID_ON_WAIT && cnt_done) begin
                dq_out <= ID_BYTE;
                dq_oe  <= 1'b1;
            end else if (state == ID_OFF_WAIT && cnt_done) begin
                dq_out <= '1;
                dq_oe  <= 1'b1;
            end else if (state == ID_HIGH && cmd_valid) begin
                dq_out <= '0;
                dq_oe  <= 1'b0;
            end
        end
    end

    p_wait_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ID_ON_WAIT) |-> !dq_oe);
    p_show_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ID_SHOW) |-> (dq_oe && dq_out == ID_BYTE));
    p_exit_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act.id_exit |=> ($stable(dq_out) && $stable(dq_oe)));
    p_high_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ID_HIGH) |-> (dq_oe && dq_out == 8'hFF));

endmodule

// File: rtl/gdram_xmode_ctrl.sv
// Top of the extended mode register controller. It ties the decoder, DLL
// tracker, field registers and ID sequencer together and registers the
// refused-command flag. Assumes one command per cycle at most.
module gdram_xmode_ctrl
    import gdram_xmode_pkg::*;
#(
    parameter int LOCK_CYCLES    = 1000,
    parameter int ID_ON_DLY      = 4,
    parameter int ID_OFF_DLY     = 4,
    parameter bit HIGH_SPEED_MAP = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_code,
    input  logic [11:0] cmd_addr,
    output logic        read_ok,
    output logic        cmd_illegal,
    output logic        dll_on,
    output logic [7:0]  dq_out,
    output logic        dq_oe,
    output logic [3:0]  wr_cycles,
    output logic [1:0]  term_sel,
    output logic [1:0]  drv_sel
);

    cmd_act_t   act;
    logic       id_active;
    logic       in_sref;
    logic [2:0] wr_code;
    logic [1:0] term_code;
    logic [1:0] drv_code;

    gdram_xmode_decode #(.HIGH_SPEED_MAP(HIGH_SPEED_MAP)) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_addr  (cmd_addr),
        .id_active (id_active),
        .in_sref   (in_sref),
        .dll_on    (dll_on),
        .read_ok   (read_ok),
        .act       (act),
        .wr_code   (wr_code),
        .term_code (term_code),
        .drv_code  (drv_code)
    );

    gdram_xmode_dll #(.LOCK_CYCLES(LOCK_CYCLES)) u_dll (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .dll_on  (dll_on),
        .in_sref (in_sref),
        .read_ok (read_ok)
    );

    gdram_xmode_fields #(.HIGH_SPEED_MAP(HIGH_SPEED_MAP)) u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .wr_code_in (wr_code),
        .term_in    (term_code),
        .drv_in     (drv_code),
        .wr_cycles  (wr_cycles),
        .term_sel   (term_sel),
        .drv_sel    (drv_sel)
    );

    gdram_xmode_idread #(.ON_DLY(ID_ON_DLY), .OFF_DLY(ID_OFF_DLY)) u_idread (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .cmd_valid (cmd_valid),
        .id_active (id_active),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    // One-cycle refused-command pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_illegal <= 1'b0;
        else        cmd_illegal <= act.illegal;
    end

    p_early_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd1 && !read_ok) |=> cmd_illegal);
    p_id_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && id_active && !(cmd_code == 3'd7 && !cmd_addr[10])) |=> cmd_illegal);
    p_sref_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && in_sref && !id_active && cmd_code != 3'd6) |=> cmd_illegal);

endmodule

// File: tb/gdram_xmode_ctrl_bench.sv
`timescale 1ns/1ps
module gdram_xmode_ctrl_bench;

    localparam int LOCK = 20;
    localparam int RIDON = 4;
    localparam int RDOFF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = '0;
    logic [11:0] cmd_addr = '0;

    logic       read_ok, cmd_illegal, dll_on, dq_oe;
    logic [7:0] dq_out;
    logic [3:0] wr_cycles;
    logic [1:0] term_sel, drv_sel;

    logic       m_read_ok, m_cmd_illegal, m_dll_on, m_dq_oe;
    logic [7:0] m_dq_out;
    logic [3:0] m_wr_cycles;
    logic [1:0] m_term_sel, m_drv_sel;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gdram_xmode_ctrl #(.LOCK_CYCLES(LOCK), .ID_ON_DLY(RIDON), .ID_OFF_DLY(RDOFF),
                       .HIGH_SPEED_MAP(1'b1)) u_gdram_xmode_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .read_ok(read_ok), .cmd_illegal(cmd_illegal),
        .dll_on(dll_on), .dq_out(dq_out), .dq_oe(dq_oe), .wr_cycles(wr_cycles),
        .term_sel(term_sel), .drv_sel(drv_sel));

    gdram_xmode_ctrl #(.LOCK_CYCLES(LOCK), .ID_ON_DLY(RIDON), .ID_OFF_DLY(RDOFF),
                       .HIGH_SPEED_MAP(1'b0)) u_gdram_xmode_ctrl_mid (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .read_ok(m_read_ok), .cmd_illegal(m_cmd_illegal),
        .dll_on(m_dll_on), .dq_out(m_dq_out), .dq_oe(m_dq_oe), .wr_cycles(m_wr_cycles),
        .term_sel(m_term_sel), .drv_sel(m_drv_sel));

    // Reference model state
    bit  r_dll, r_sref, r_ill, r_ill_mid, r_oe;
    int  r_lock, r_st, r_cnt, r_wr, r_wr_mid, r_term, r_drv;
    logic [7:0] r_dq;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, advanced on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            r_dll = 0; r_sref = 0; r_ill = 0; r_ill_mid = 0; r_oe = 0; r_dq = 0;
            r_lock = 0; r_st = 0; r_cnt = 0; r_wr = 0; r_wr_mid = 0; r_term = 0; r_drv = 0;
        end else begin
            bit id_act, rok, enter, leave, emrs_path;
            int wrc, tc, dc;
            id_act = (r_st == 1 || r_st == 2);
            rok = r_dll && r_lock == 0 && !r_sref;
            enter = 0; leave = 0; emrs_path = 0;
            r_ill = 0; r_ill_mid = 0;
            wrc = {cmd_addr[7], cmd_addr[5], cmd_addr[4]};
            tc = cmd_addr[1:0];
            dc = cmd_addr[3:2];
            if (r_lock > 0) r_lock--;
            if (cmd_valid) begin
                if (id_act) begin
                    if (cmd_code == 7 && !cmd_addr[10]) leave = 1; else r_ill = 1;
                end else if (r_sref) begin
                    if (cmd_code == 6) begin r_sref = 0; r_dll = 1; r_lock = LOCK; end
                    else r_ill = 1;
                end else begin
                    case (cmd_code)
                        1: if (!rok) r_ill = 1;
                        5: r_sref = 1;
                        6: r_ill = 1;
                        7: begin
                            if (cmd_addr[10]) enter = 1;
                            else begin
                                emrs_path = 1;
                                if (tc == 3) r_ill_mid = 1; else r_wr_mid = wrc;
                                if (tc == 3 || wrc == 7) r_ill = 1;
                                else begin
                                    r_wr = wrc; r_term = tc; r_drv = dc;
                                    if (cmd_addr[6]) begin r_dll = 0; r_lock = 0; end
                                    else if (!r_dll) begin r_dll = 1; r_lock = LOCK; end
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            if (!emrs_path) r_ill_mid = r_ill;
            if (leave) begin
                r_st = 3; r_cnt = RDOFF - 1;
            end else if (enter) begin
                r_st = 1; r_cnt = RIDON - 1; r_dq = 0; r_oe = 0;
            end else if (r_st == 1) begin
                if (r_cnt == 0) begin r_st = 2; r_dq = 8'h32; r_oe = 1; end else r_cnt--;
            end else if (r_st == 3) begin
                if (r_cnt == 0) begin r_st = 4; r_dq = 8'hFF; r_oe = 1; end else r_cnt--;
            end else if (r_st == 4 && cmd_valid) begin
                r_st = 0; r_dq = 0; r_oe = 0;
            end
        end
    end

    // Compare every output with the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 read_ok", read_ok, (r_dll && r_lock == 0 && !r_sref));
            check("R3 cmd_illegal", cmd_illegal, r_ill);
            check("R4 dll_on", dll_on, r_dll);
            check("R8 dq_out", dq_out, r_dq);
            check("R9 dq_oe", dq_oe, r_oe);
            check("R5 wr_cycles high map", wr_cycles, r_wr + 7);
            check("R6 term_sel", term_sel, r_term);
            check("R6 drv_sel", drv_sel, r_drv);
            check("R5 wr_cycles mid map", m_wr_cycles, r_wr_mid + 4);
            check("R7 cmd_illegal mid map", m_cmd_illegal, r_ill_mid);
        end
    end

    function automatic logic [11:0] mk(bit a10, bit a6, int wr, int term, int drv);
        logic [2:0] w;
        w = 3'(wr);
        return {1'b0, a10, 2'b00, w[2], a6, w[1], w[0], 2'(drv), 2'(term)};
    endfunction

    task automatic issue(int code, logic [11:0] addr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'(code); cmd_addr = addr;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = '0; cmd_addr = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 read_ok", read_ok, 0);
        check("R1 dll_on", dll_on, 0);
        check("R1 dq_oe", dq_oe, 0);
        check("R1 dq_out", dq_out, 0);
        check("R1 wr_cycles", wr_cycles, 7);
        check("R1 wr_cycles mid", m_wr_cycles, 4);
        check("R1 term_sel", term_sel, 0);
        rst_n = 1'b1;

        issue(1, '0);                         // R3: read with DLL off
        issue(7, mk(0, 0, 2, 1, 2));          // R2: enable DLL, set fields
        for (int i = 0; i < LOCK + 3; i++) issue(1, '0);  // R3: read across lock boundary
        issue(7, mk(0, 0, 3, 3, 1));          // R6/R7: reserved termination
        issue(7, mk(0, 0, 7, 2, 3));          // R5: code 7 refused only in high map
        issue(7, mk(0, 0, 6, 2, 3));          // R5: highest valid code
        issue(7, mk(0, 1, 1, 0, 0));          // R2: disable DLL
        issue(1, '0);
        issue(7, mk(0, 0, 0, 1, 1));          // R2: re-enable
        idle(LOCK + 2);
        issue(1, '0);
        issue(5, '0);                         // R4: self-refresh entry
        issue(1, '0);
        issue(2, '0);
        issue(7, mk(0, 0, 4, 2, 2));          // R4: EMRS refused inside self-refresh
        issue(6, '0);                         // R4: exit restarts lock
        for (int i = 0; i < LOCK + 2; i++) issue(1, '0);
        issue(6, '0);                         // R4: exit outside self-refresh

        // R8/R9/R10: full identification cycle
        issue(7, mk(1, 0, 0, 0, 0));
        idle(RIDON + 2);
        issue(1, '0);                         // R10: refused
        issue(7, mk(1, 0, 5, 2, 1));          // R10: second entry refused
        issue(5, '0);                         // R10: no self-refresh
        issue(7, mk(0, 1, 5, 2, 1));          // R9: exit, fields and DLL untouched
        idle(RDOFF + 3);
        issue(2, '0);                         // R9: releases bus
        idle(3);

        // R8/R9: exits at each offset of the on-delay window
        for (int d = 0; d < RIDON + 2; d++) begin
            issue(7, mk(1, 0, 0, 0, 0));
            idle(d);
            issue(7, mk(0, 0, 0, 0, 0));
            idle(RDOFF + 1);
            issue(3, '0);
            idle(2);
        end
        // R8: re-entry from the parked-high phase
        issue(7, mk(1, 0, 0, 0, 0));
        idle(1);
        issue(7, mk(0, 0, 0, 0, 0));
        idle(RDOFF + 1);
        issue(7, mk(1, 0, 0, 0, 0));
        idle(RIDON + 1);
        issue(7, mk(0, 0, 0, 0, 0));
        idle(RDOFF + 2);
        issue(4, '0);
        idle(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule